// File: doc/BRIEF.md
# Data Abort Classifier and Base Restore Unit

This unit sits next to the load/store stage of a pipeline. Each completing memory access brings its fault indications: a vector of internal translation-check faults, an external bus error (or, for a cacheable linefill, a per-word error mask), and the attributes of the instruction. The unit decides whether an abort is precise or imprecise. It picks a fault status code and captures the fault address. It raises a one-cycle exception request that carries the return link value.

Precise aborts squash younger work in the same cycle. On the next cycle they write the base register's pre-instruction value back into the register file, so the handler never has to undo base writeback. Imprecise aborts are held in a pending flag. They are taken at a later instruction boundary, but only while the abort mask is clear. Prefetch aborts use the same request path with a different link offset.

Top module: `dabort_unit`

## Requirements
- R1: When several fault bits are set together on `mmu_flt`, the lowest-numbered bit wins. The bit order is [0] alignment, [1] translation, [2] access flag, [3] domain, [4] permission. The reported `fsr` codes are 5'h01, 5'h05, 5'h03, 5'h09 and 5'h0D respectively.
- R2: Any nonzero `mmu_flt` on a valid access is a precise data abort. The cycle after, `exc_req`=1, `exc_data`=1 and `exc_imp`=0.
- R3: An external error is precise when any of these holds: the memory is strongly ordered (`mem_so`), the access is a load with a PC/status destination (`is_load` and `ld_pc_psr`), or it is the load half of a swap (`swap_load`).
- R4: Any other external error is imprecise. It raises no request and no squash. It sets `imp_pending` on the next cycle.
- R5: A precise external abort reports `fsr` 5'h08. A taken imprecise abort reports `fsr` 5'h16.
- R6: When `linefill`=1, `ext_err` is ignored and only `line_err[req_word]` counts as an error. Errors on other words of the line raise nothing.
- R7: The cycle after a precise data abort with `base_wb`=1, `rf_restore_en`=1, and `rf_restore_idx`/`rf_restore_val` carry the base index and value captured at the last `issue_valid`. A precise abort with `base_wb`=0, or any imprecise abort, gives no restore.
- R8: For a data abort, `exc_link` is the instruction address plus 8. For an imprecise abort this is `bnd_addr`+8. For a prefetch abort (`pf_abort`) it is `pf_addr`+4, with `exc_data`=0 and `fsr` left unchanged.
- R9: `squash` is high in the same cycle as a precise data abort and low otherwise.
- R10: A pending imprecise abort is taken only in a cycle with `at_boundary`=1, `abort_mask`=0 and no precise data abort or prefetch abort. Taking it clears `imp_pending`.
- R11: `far` loads `acc_addr` on a precise data abort. It holds its value on imprecise aborts and prefetch aborts.
- R12: After reset, `exc_req`, `squash`, `imp_pending`, `rf_restore_en`, `fsr` and `far` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction issues; capture base snapshot |
| issue_base_idx | input | RIDX_W | Base register index at issue |
| issue_base_val | input | DW | Base register value before execution |
| acc_valid | input | 1 | Memory access completes this cycle |
| acc_addr | input | AW | Data address of the access |
| insn_addr | input | AW | Address of the instruction making the access |
| mmu_flt | input | 5 | Internal fault vector (see R1) |
| ext_err | input | 1 | External error response (non-linefill) |
| linefill | input | 1 | Access is a cacheable linefill |
| line_err | input | LINE_WORDS | Per-word error flags of the linefill |
| req_word | input | WSEL_W | Word the core requested within the line |
| mem_so | input | 1 | Strongly-ordered memory |
| is_load | input | 1 | Access is a load |
| ld_pc_psr | input | 1 | Load destination is PC or status register |
| swap_load | input | 1 | Load half of a swap |
| base_wb | input | 1 | Instruction requests base writeback |
| pf_abort | input | 1 | Prefetch abort on an instruction fetch |
| pf_addr | input | AW | Address of the aborted fetch |
| at_boundary | input | 1 | Instruction boundary this cycle |
| bnd_addr | input | AW | Address of the instruction at the boundary |
| abort_mask | input | 1 | Masks imprecise abort delivery |
| squash | output | 1 | Kill younger instructions and their writes |
| exc_req | output | 1 | Exception request pulse |
| exc_data | output | 1 | 1 = data abort, 0 = prefetch abort |
| exc_imp | output | 1 | Request is an imprecise abort |
| exc_link | output | AW | Link value for the handler |
| fsr | output | 5 | Fault status code |
| far | output | AW | Fault address |
| imp_pending | output | 1 | Imprecise abort waiting |
| rf_restore_en | output | 1 | Register file base restore write |
| rf_restore_idx | output | RIDX_W | Restore register index |
| rf_restore_val | output | DW | Restore value |

## Verification
The bench builds the unit with AW=12, DW=16, RIDX_W=4 and LINE_WORDS=4. These sizes make several sweeps complete:

- all 31 nonzero internal-fault combinations;
- all 16 combinations of the four attributes that classify external errors;
- every 4-bit linefill error mask against every requested word.

Each imprecise case is then delivered through a masked boundary and an unmasked one. Together these runs cover fault priority, precise versus imprecise sorting, word selection, the mask gate and the base restore.

// File: rtl/dab_pkg.sv
package dab_pkg;

    localparam int FLT_N = 5;

    localparam logic [4:0] FSR_ALIGN   = 5'h01;
    localparam logic [4:0] FSR_XLAT    = 5'h05;
    localparam logic [4:0] FSR_ACCFLAG = 5'h03;
    localparam logic [4:0] FSR_DOMAIN  = 5'h09;
    localparam logic [4:0] FSR_PERM    = 5'h0D;
    localparam logic [4:0] FSR_EXT_PRE = 5'h08;
    localparam logic [4:0] FSR_EXT_IMP = 5'h16;

    typedef struct packed {
        logic       hit;
        logic       precise;
        logic [4:0] code;
    } abort_cls_t;

    // lowest set bit wins: alignment first, permission last
    function automatic logic [4:0] mmu_code(input logic [FLT_N-1:0] f);
        logic [4:0] c;
        c = 5'h00;
        if (f[4]) c = FSR_PERM;
        if (f[3]) c = FSR_DOMAIN;
        if (f[2]) c = FSR_ACCFLAG;
        if (f[1]) c = FSR_XLAT;
        if (f[0]) c = FSR_ALIGN;
        return c;
    endfunction

endpackage

// File: rtl/dab_classify.sv
module dab_classify
    import dab_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    parameter int WSEL_W     = 3
) (
    input  logic [FLT_N-1:0]      mmu_flt,
    input  logic                  ext_err,
    input  logic                  linefill,
    input  logic [LINE_WORDS-1:0] line_err,
    input  logic [WSEL_W-1:0]     req_word,
    input  logic                  mem_so,
    input  logic                  is_load,
    input  logic                  ld_pc_psr,
    input  logic                  swap_load,
    output abort_cls_t            cls
);
    logic word_err;
    logic eff_err;
    logic ext_precise;

    always_comb begin
        word_err = 1'b0;
        for (int i = 0; i < LINE_WORDS; i++) begin
            if (req_word == WSEL_W'(i)) word_err = line_err[i];
        end
    end

    assign eff_err     = linefill ? word_err : ext_err;
    assign ext_precise = mem_so | (is_load & ld_pc_psr) | swap_load;

    always_comb begin
        cls = '0;
        if (|mmu_flt) begin
            cls.hit     = 1'b1;
            cls.precise = 1'b1;
            cls.code    = mmu_code(mmu_flt);
        end else if (eff_err) begin
            cls.hit     = 1'b1;
            cls.precise = ext_precise;
            cls.code    = ext_precise ? FSR_EXT_PRE : FSR_EXT_IMP;
        end
    end
endmodule

// File: rtl/dab_base_snap.sv
module dab_base_snap #(
    parameter int RIDX_W = 4,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [RIDX_W-1:0] cap_idx,
    input  logic [DW-1:0]     cap_val,
    output logic [RIDX_W-1:0] snap_idx,
    output logic [DW-1:0]     snap_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_idx <= '0;
            snap_val <= '0;
        end else if (cap) begin
            snap_idx <= cap_idx;
            snap_val <= cap_val;
        end
    end
endmodule

// File: rtl/dab_imp_pend.sv
module dab_imp_pend (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic take,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)       pending <= 1'b0;
        else if (set)  pending <= 1'b1;
        else if (take) pending <= 1'b0;
    end
endmodule

// File: rtl/dabort_unit.sv
module dabort_unit
    import dab_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int RIDX_W     = 4,
    parameter int LINE_WORDS = 8,
    localparam int WSEL_W    = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue_valid,
    input  logic [RIDX_W-1:0]     issue_base_idx,
    input  logic [DW-1:0]         issue_base_val,
    input  logic                  acc_valid,
    input  logic [AW-1:0]         acc_addr,
    input  logic [AW-1:0]         insn_addr,
    input  logic [4:0]            mmu_flt,
    input  logic                  ext_err,
    input  logic                  linefill,
    input  logic [LINE_WORDS-1:0] line_err,
    input  logic [WSEL_W-1:0]     req_word,
    input  logic                  mem_so,
    input  logic                  is_load,
    input  logic                  ld_pc_psr,
    input  logic                  swap_load,
    input  logic                  base_wb,
    input  logic                  pf_abort,
    input  logic [AW-1:0]         pf_addr,
    input  logic                  at_boundary,
    input  logic [AW-1:0]         bnd_addr,
    input  logic                  abort_mask,
    output logic                  squash,
    output logic                  exc_req,
    output logic                  exc_data,
    output logic                  exc_imp,
    output logic [AW-1:0]         exc_link,
    output logic [4:0]            fsr,
    output logic [AW-1:0]         far,
    output logic                  imp_pending,
    output logic                  rf_restore_en,
    output logic [RIDX_W-1:0]     rf_restore_idx,
    output logic [DW-1:0]         rf_restore_val
);
    localparam logic [AW-1:0] DATA_OFS = AW'(8);
    localparam logic [AW-1:0] PF_OFS   = AW'(4);

    abort_cls_t        cls;
    logic              precise_ev;
    logic              imp_ev;
    logic              pf_ev;
    logic              take_imp;
    logic [RIDX_W-1:0] snap_idx;
    logic [DW-1:0]     snap_val;

    dab_classify #(.LINE_WORDS(LINE_WORDS), .WSEL_W(WSEL_W)) u_cls (
        .mmu_flt   (mmu_flt),
        .ext_err   (ext_err),
        .linefill  (linefill),
        .line_err  (line_err),
        .req_word  (req_word),
        .mem_so    (mem_so),
        .is_load   (is_load),
        .ld_pc_psr (ld_pc_psr),
        .swap_load (swap_load),
        .cls       (cls)
    );

    dab_base_snap #(.RIDX_W(RIDX_W), .DW(DW)) u_snap (
        .clk      (clk),
        .rst      (rst),
        .cap      (issue_valid),
        .cap_idx  (issue_base_idx),
        .cap_val  (issue_base_val),
        .snap_idx (snap_idx),
        .snap_val (snap_val)
    );

    assign precise_ev = acc_valid & cls.hit & cls.precise;
    assign imp_ev     = acc_valid & cls.hit & ~cls.precise;
    assign pf_ev      = pf_abort & ~precise_ev;
    assign take_imp   = imp_pending & at_boundary & ~abort_mask & ~precise_ev & ~pf_abort;
    assign squash     = precise_ev;

    dab_imp_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .set     (imp_ev),
        .take    (take_imp),
        .pending (imp_pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_req        <= 1'b0;
            exc_data       <= 1'b0;
            exc_imp        <= 1'b0;
            exc_link       <= '0;
            fsr            <= '0;
            far            <= '0;
            rf_restore_en  <= 1'b0;
            rf_restore_idx <= '0;
            rf_restore_val <= '0;
        end else begin
            exc_req        <= precise_ev | pf_ev | take_imp;
            rf_restore_en  <= precise_ev & base_wb;
            rf_restore_idx <= snap_idx;
            rf_restore_val <= snap_val;
            if (precise_ev) begin
                exc_data <= 1'b1;
                exc_imp  <= 1'b0;
                exc_link <= insn_addr + DATA_OFS;
                fsr      <= cls.code;
                far      <= acc_addr;
            end else if (pf_ev) begin
                exc_data <= 1'b0;
                exc_imp  <= 1'b0;
                exc_link <= pf_addr + PF_OFS;
            end else if (take_imp) begin
                exc_data <= 1'b1;
                exc_imp  <= 1'b1;
                exc_link <= bnd_addr + DATA_OFS;
                fsr      <= FSR_EXT_IMP;
            end
        end
    end
endmodule

// File: rtl/dabort_unit_chk.sv
module dabort_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          squash,
    input logic          exc_req,
    input logic          exc_data,
    input logic          exc_imp,
    input logic [AW-1:0] exc_link,
    input logic [4:0]    fsr,
    input logic [AW-1:0] far,
    input logic          rf_restore_en,
    input logic          at_boundary,
    input logic          abort_mask,
    input logic          pf_abort,
    input logic [AW-1:0] pf_addr
);
    // R9
    squash_req_chk: assert property (@(posedge clk) disable iff (rst)
        squash |=> (exc_req && exc_data && !exc_imp));

    // R10
    imp_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req && exc_imp) |-> ($past(at_boundary) && !$past(abort_mask)));

    // R11
    far_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req && exc_imp) |-> $stable(far));

    // R5
    imp_code_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req && exc_imp) |-> (fsr == 5'h16));

    // R8
    pf_link_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !exc_data) |-> (exc_link == $past(pf_addr) + AW'(4)) && $past(pf_abort));

    // R7
    restore_chk: assert property (@(posedge clk) disable iff (rst)
        rf_restore_en |-> (exc_req && exc_data && !exc_imp));
endmodule

bind dabort_unit dabort_unit_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .squash        (squash),
    .exc_req       (exc_req),
    .exc_data      (exc_data),
    .exc_imp       (exc_imp),
    .exc_link      (exc_link),
    .fsr           (fsr),
    .far           (far),
    .rf_restore_en (rf_restore_en),
    .at_boundary   (at_boundary),
    .abort_mask    (abort_mask),
    .pf_abort      (pf_abort),
    .pf_addr       (pf_addr)
);

// File: tb/test_dabort_unit.sv
`timescale 1ns/100ps
module test_dabort_unit;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int RW = 4;
    localparam int LW = 4;
    localparam int WS = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_valid = 0;
    logic [RW-1:0] issue_base_idx = '0;
    logic [DW-1:0] issue_base_val = '0;
    logic          acc_valid = 0;
    logic [AW-1:0] acc_addr = '0, insn_addr = '0;
    logic [4:0]    mmu_flt = '0;
    logic          ext_err = 0, linefill = 0;
    logic [LW-1:0] line_err = '0;
    logic [WS-1:0] req_word = '0;
    logic          mem_so = 0, is_load = 0, ld_pc_psr = 0, swap_load = 0, base_wb = 0;
    logic          pf_abort = 0;
    logic [AW-1:0] pf_addr = '0;
    logic          at_boundary = 0;
    logic [AW-1:0] bnd_addr = '0;
    logic          abort_mask = 0;
    logic          squash, exc_req, exc_data, exc_imp, imp_pending, rf_restore_en;
    logic [AW-1:0] exc_link, far;
    logic [4:0]    fsr;
    logic [RW-1:0] rf_restore_idx;
    logic [DW-1:0] rf_restore_val;

    int checks = 0;
    int errors = 0;
    logic squash_seen;
    logic [AW-1:0] exp_far = '0;
    logic [4:0]    exp_fsr = '0;

    always #2.5 clk = ~clk;

    dabort_unit #(.AW(AW), .DW(DW), .RIDX_W(RW), .LINE_WORDS(LW)) i_dabort_unit (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_base_idx(issue_base_idx),
        .issue_base_val(issue_base_val), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .insn_addr(insn_addr), .mmu_flt(mmu_flt), .ext_err(ext_err), .linefill(linefill),
        .line_err(line_err), .req_word(req_word), .mem_so(mem_so), .is_load(is_load),
        .ld_pc_psr(ld_pc_psr), .swap_load(swap_load), .base_wb(base_wb), .pf_abort(pf_abort),
        .pf_addr(pf_addr), .at_boundary(at_boundary), .bnd_addr(bnd_addr),
        .abort_mask(abort_mask), .squash(squash), .exc_req(exc_req), .exc_data(exc_data),
        .exc_imp(exc_imp), .exc_link(exc_link), .fsr(fsr), .far(far),
        .imp_pending(imp_pending), .rf_restore_en(rf_restore_en),
        .rf_restore_idx(rf_restore_idx), .rf_restore_val(rf_restore_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_mmu(input logic [4:0] f);
        logic [4:0] codes [5];
        codes[0] = 5'h01; codes[1] = 5'h05; codes[2] = 5'h03; codes[3] = 5'h09; codes[4] = 5'h0D;
        for (int b = 0; b < 5; b++) if (f[b]) return codes[b];
        return 5'h00;
    endfunction

    // drive one access at negedge, sample squash before the edge, return after the edge
    task automatic do_acc(input logic [4:0] m, input logic e, input logic lf,
                          input logic [LW-1:0] le, input logic [WS-1:0] w,
                          input logic [3:0] attr, input logic wb,
                          input logic [AW-1:0] a, input logic [AW-1:0] ia);
        @(negedge clk);
        acc_valid = 1; mmu_flt = m; ext_err = e; linefill = lf; line_err = le;
        req_word = w; {mem_so, is_load, ld_pc_psr, swap_load} = attr; base_wb = wb;
        acc_addr = a; insn_addr = ia;
        #1 squash_seen = squash;
        @(posedge clk); #1;
        acc_valid = 0; mmu_flt = 0; ext_err = 0; linefill = 0; line_err = 0; base_wb = 0;
    endtask

    task automatic take_pending(input logic [AW-1:0] ba);
        @(negedge clk);
        at_boundary = 1; abort_mask = 1; bnd_addr = ba;
        @(posedge clk); #1;
        chk("R10 masked no req", exc_req, 0);
        chk("R10 masked still pending", imp_pending, 1);
        abort_mask = 0;
        @(posedge clk); #1;
        at_boundary = 0;
        chk("R10 taken req", exc_req, 1);
        chk("R10 taken imp", exc_imp, 1);
        chk("R10 cleared", imp_pending, 0);
        chk("R5 imp code", fsr, 5'h16);
        chk("R8 imp link", exc_link, 32'(AW'(ba + 8)));
        chk("R11 far kept", far, exp_far);
        exp_fsr = 5'h16;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R12
        chk("R12 exc_req", exc_req, 0);
        chk("R12 squash", squash, 0);
        chk("R12 pending", imp_pending, 0);
        chk("R12 restore", rf_restore_en, 0);
        chk("R12 fsr", fsr, 0);
        chk("R12 far", far, 0);

        // R1/R2: every internal fault combination, external error also present
        for (int m = 1; m < 32; m++) begin
            logic [AW-1:0] a;
            a = AW'(m * 37 + 5);
            do_acc(5'(m), 1'b1, 1'b0, '0, '0, 4'h0, 1'b0, a, AW'(m * 4));
            exp_far = a; exp_fsr = exp_mmu(5'(m));
            chk("R1 code", fsr, exp_fsr);
            chk("R2 req", exc_req, 1);
            chk("R2 precise", exc_imp, 0);
            chk("R9 squash", squash_seen, 1);
            chk("R11 far", far, exp_far);
            chk("R8 data link", exc_link, 32'(AW'(m * 4 + 8)));
        end

        // R3/R4: external error attribute sweep {so, load, pcpsr, swap}
        for (int at = 0; at < 16; at++) begin
            logic pre;
            logic [3:0] av;
            av = 4'(at);
            pre = av[3] | (av[2] & av[1]) | av[0];
            do_acc(5'h0, 1'b1, 1'b0, '0, '0, av, 1'b1, AW'(at * 11 + 100), AW'(at * 8));
            if (pre) begin
                exp_far = AW'(at * 11 + 100);
                chk("R3 precise req", exc_req, 1);
                chk("R3 squash", squash_seen, 1);
                chk("R5 precise code", fsr, 5'h08);
                chk("R11 far", far, exp_far);
                chk("R7 restore on wb", rf_restore_en, 1);
            end else begin
                chk("R4 no req", exc_req, 0);
                chk("R4 no squash", squash_seen, 0);
                chk("R4 pending", imp_pending, 1);
                chk("R11 far held", far, exp_far);
                chk("R7 no restore imprecise", rf_restore_en, 0);
                take_pending(AW'(at * 16 + 3));
            end
        end

        // R6: linefill word selection, strongly ordered so errors are precise
        for (int le = 0; le < 16; le++) begin
            for (int w = 0; w < 4; w++) begin
                logic [3:0] lv;
                lv = 4'(le);
                do_acc(5'h0, 1'b1, 1'b1, lv, WS'(w), 4'b1000, 1'b0, AW'(le * 4 + w), AW'(64));
                chk("R6 word select", exc_req, lv[w]);
                if (lv[w]) exp_far = AW'(le * 4 + w);
                chk("R6 far", far, exp_far);
            end
        end

        // R7: base restore from snapshot
        @(negedge clk);
        issue_valid = 1; issue_base_idx = 4'hA; issue_base_val = 16'hBEEF;
        @(negedge clk);
        issue_valid = 0; issue_base_idx = 4'h3; issue_base_val = 16'h1111;
        do_acc(5'h04, 1'b0, 1'b0, '0, '0, 4'h4, 1'b1, AW'(12'h321), AW'(12'h200));
        exp_far = AW'(12'h321);
        chk("R7 restore en", rf_restore_en, 1);
        chk("R7 restore idx", rf_restore_idx, 4'hA);
        chk("R7 restore val", rf_restore_val, 16'hBEEF);
        do_acc(5'h04, 1'b0, 1'b0, '0, '0, 4'h4, 1'b0, AW'(12'h322), AW'(12'h204));
        exp_far = AW'(12'h322);
        chk("R7 no restore without wb", rf_restore_en, 0);

        // R8: prefetch abort
        exp_fsr = fsr;
        @(negedge clk);
        pf_abort = 1; pf_addr = AW'(12'h7F0);
        @(posedge clk); #1;
        pf_abort = 0;
        chk("R8 pf req", exc_req, 1);
        chk("R8 pf kind", exc_data, 0);
        chk("R8 pf link", exc_link, 32'(AW'(12'h7F4)));
        chk("R8 pf fsr kept", fsr, exp_fsr);
        chk("R11 pf far kept", far, exp_far);

        // R10: boundary with pending blocked by a simultaneous prefetch abort
        do_acc(5'h0, 1'b1, 1'b0, '0, '0, 4'h0, 1'b0, AW'(1), AW'(2));
        @(negedge clk);
        at_boundary = 1; pf_abort = 1; pf_addr = AW'(12'h100);
        @(posedge clk); #1;
        pf_abort = 0; at_boundary = 0;
        chk("R10 pf wins", exc_imp, 0);
        chk("R10 still pending", imp_pending, 1);
        take_pending(AW'(12'h440));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule